// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block holds the digital control of a memory-channel clock generator. It takes an active-low power-down request, an active-low clock-stop request, a two-bit output-mode field and a two-bit multiplier field. From these it decides which clock source feeds the differential output driver (phase-aligned, PLL direct, reference, or none), how that driver behaves (driving, parked at its stop level, grounded, or high impedance) and which feedback/prescale divider pair the PLL uses.

Every control input, and a monitored copy of the output clock, passes through a two-flop synchronizer on the free-running system clock before decoding. The block then watches the stop protocol: it measures on-time before each new stop and the length of each stop in system-clock cycles, scaled by a cycles-per-microsecond parameter. Each broken rule sets a sticky error bit. It also counts output-clock rising edges after the output is re-enabled and raises a settled flag. After reset the block goes straight to whatever state the synchronized inputs select. There is no power-up sequence.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: While `pwr_dn_n` is 0, `drv_state` is 2 (grounded) and `src_sel` is 0 (none), whatever the other inputs are.
- R2: With `pwr_dn_n`=1 and `clk_stop_n`=0, `drv_state` is 1 (parked) and `src_sel` still follows `mode_sel` as in R3.
- R3: With both active-low inputs high, `mode_sel` decodes as follows: 2'b00 gives src 1 (phase-aligned) with drive 0 (driving), 2'b01 gives src 2 (PLL direct) with drive 0, 2'b11 gives src 3 (reference) with drive 0, and 2'b10 gives src 0 with drive 3 (high impedance).
- R4: `mult_sel` selects `fb_div`/`pre_div` as follows: 2'b00 gives 4/1, 2'b10 gives 6/1, 2'b11 gives 8/1 and 2'b01 gives 8/3.
- R5: A change on any control input shows on the outputs after exactly three rising edges of `clk`, and not after two.
- R6: `err_min_on` sets if clock-stop is asserted again after fewer than ceil(MIN_ON_NS*CYC_PER_US/1000) enabled cycles. A stop that follows a longer on-time, or the first stop after reset or power-down, leaves it clear.
- R7: `err_max_stop` sets once clock-stop has been held for more than MAX_STOP_US*CYC_PER_US cycles. A shorter stop leaves it clear.
- R8: Every error bit, once set, stays set until reset.
- R9: `settled` is 0 while the output is stopped or powered down. It rises after SETTLE_EDGES rising edges of `out_clk_mon` counted while the output is enabled, and not before.
- R10: `err_mult_test` sets if `mult_sel` changes while `mode_sel` is 2'b11. The same change in any other mode leaves it clear.
- R11: During and just after reset, `drv_state` is 2, `src_sel` is 0, `settled` is 0 and all error bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_dn_n | input | 1 | Active-low power-down request |
| clk_stop_n | input | 1 | Active-low clock-stop request |
| mode_sel | input | 2 | Output mode field |
| mult_sel | input | 2 | PLL multiplier field |
| out_clk_mon | input | 1 | Monitored output clock, used for settle counting |
| src_sel | output | 2 | Selected output source: 0 none, 1 phase-aligned, 2 PLL, 3 reference |
| drv_state | output | 2 | Driver state: 0 driving, 1 parked, 2 grounded, 3 high impedance |
| fb_div | output | 4 | PLL feedback divider |
| pre_div | output | 2 | PLL prescale divider |
| settled | output | 1 | Output phase settled after re-enable |
| err_min_on | output | 1 | Sticky: stop asserted too soon after release |
| err_max_stop | output | 1 | Sticky: stop held too long |
| err_mult_test | output | 1 | Sticky: multiplier changed in reference mode |

## Verification
The decode is driven with random combinations of all four control fields, each held long enough to pass the synchronizers. This separates power-down priority from stop priority, and both from the four mode decodes and the four divider pairs. Directed sequences then cover the rest. Short and long on-times before a stop show whether the minimum-on check fires only below the limit. Stops well under and well over the limit show the same for the maximum-stop check. Counting output edges below and above the settle count shows the flag rises at the right edge count and falls on a new stop. A multiplier change inside and outside reference mode shows that the stability check is confined to that mode.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_PHASE = 2'd1,
        SRC_PLL   = 2'd2,
        SRC_REF   = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        DRV_ON   = 2'd0,
        DRV_PARK = 2'd1,
        DRV_GND  = 2'd2,
        DRV_HIZ  = 2'd3
    } drv_e;

    localparam logic [1:0] MODE_PHASE = 2'b00;
    localparam logic [1:0] MODE_PLL   = 2'b01;
    localparam logic [1:0] MODE_REF   = 2'b11;
    localparam logic [1:0] MODE_HIZ   = 2'b10;
endpackage

// File: rtl/clkgen_sync_bank.sv
module clkgen_sync_bank #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q, hold_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                hold_q <= 1'b0;
            end else begin
                meta_q <= async_in[i];
                hold_q <= meta_q;
            end
        end
        assign sync_out[i] = hold_q;
    end
endmodule

// File: rtl/clkgen_stop_guard.sv
module clkgen_stop_guard #(
    parameter int MIN_ON_CYC   = 13,
    parameter int MAX_STOP_CYC = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic stop_n,
    output logic err_min_on,
    output logic err_max_stop
);
    localparam int ON_W = $clog2(MIN_ON_CYC + 1);
    localparam int ST_W = $clog2(MAX_STOP_CYC + 1);

    typedef struct packed {
        logic [ON_W-1:0] on_cnt;
        logic [ST_W-1:0] stop_cnt;
        logic            stopped;
        logic            e_min;
        logic            e_max;
    } guard_t;

    guard_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (!pwr_on) begin
            g_d.on_cnt   = ON_W'(MIN_ON_CYC);
            g_d.stop_cnt = '0;
            g_d.stopped  = 1'b0;
        end else if (!stop_n) begin
            g_d.stopped = 1'b1;
            g_d.on_cnt  = '0;
            if (!g_q.stopped && (g_q.on_cnt < ON_W'(MIN_ON_CYC)))
                g_d.e_min = 1'b1;
            if (g_q.stop_cnt == ST_W'(MAX_STOP_CYC))
                g_d.e_max = 1'b1;
            else
                g_d.stop_cnt = g_q.stop_cnt + ST_W'(1);
        end else begin
            g_d.stopped  = 1'b0;
            g_d.stop_cnt = '0;
            if (g_q.on_cnt < ON_W'(MIN_ON_CYC))
                g_d.on_cnt = g_q.on_cnt + ON_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q          <= '0;
            g_q.on_cnt   <= ON_W'(MIN_ON_CYC);
        end else begin
            g_q <= g_d;
        end
    end

    assign err_min_on   = g_q.e_min;
    assign err_max_stop = g_q.e_max;
endmodule

// File: rtl/clkgen_settle_track.sv
module clkgen_settle_track #(
    parameter int SETTLE_EDGES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic mon_clk,
    output logic settled
);
    localparam int CW = $clog2(SETTLE_EDGES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          prev;
        logic          done;
    } settle_t;

    settle_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = mon_clk;
        if (!run) begin
            s_d.cnt  = '0;
            s_d.done = 1'b0;
        end else if (!s_q.done && mon_clk && !s_q.prev) begin
            s_d.cnt = s_q.cnt + CW'(1);
            if (s_q.cnt == CW'(SETTLE_EDGES - 1))
                s_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign settled = s_q.done;
endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
    import clkgen_pkg::*;
#(
    parameter int CYC_PER_US   = 125,
    parameter int MIN_ON_NS    = 100,
    parameter int MAX_STOP_US  = 100,
    parameter int SETTLE_EDGES = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_dn_n,
    input  logic       clk_stop_n,
    input  logic [1:0] mode_sel,
    input  logic [1:0] mult_sel,
    input  logic       out_clk_mon,
    output logic [1:0] src_sel,
    output logic [1:0] drv_state,
    output logic [3:0] fb_div,
    output logic [1:0] pre_div,
    output logic       settled,
    output logic       err_min_on,
    output logic       err_max_stop,
    output logic       err_mult_test
);
    localparam int MIN_ON_RAW   = (MIN_ON_NS * CYC_PER_US + 999) / 1000;
    localparam int MIN_ON_CYC   = (MIN_ON_RAW < 1) ? 1 : MIN_ON_RAW;
    localparam int MAX_STOP_CYC = MAX_STOP_US * CYC_PER_US;
    localparam int SYNC_W       = 7;

    logic [SYNC_W-1:0] raw_in, syn;
    logic       s_pwr, s_stop_n, s_mon;
    logic [1:0] s_mode, s_mult;

    assign raw_in = {out_clk_mon, mult_sel, mode_sel, clk_stop_n, pwr_dn_n};

    clkgen_sync_bank #(.WIDTH(SYNC_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (syn)
    );

    assign s_pwr    = syn[0];
    assign s_stop_n = syn[1];
    assign s_mode   = syn[3:2];
    assign s_mult   = syn[5:4];
    assign s_mon    = syn[6];

    typedef struct packed {
        src_e       src;
        drv_e       drv;
        logic [3:0] fb;
        logic [1:0] pre;
        logic [1:0] prev_mode;
        logic [1:0] prev_mult;
        logic       e_mult;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d           = c_q;
        c_d.prev_mode = s_mode;
        c_d.prev_mult = s_mult;

        unique case (s_mode)
            MODE_PHASE: c_d.src = SRC_PHASE;
            MODE_PLL:   c_d.src = SRC_PLL;
            MODE_REF:   c_d.src = SRC_REF;
            default:    c_d.src = SRC_NONE;
        endcase

        if (!s_pwr) begin
            c_d.src = SRC_NONE;
            c_d.drv = DRV_GND;
        end else if (!s_stop_n) begin
            c_d.drv = DRV_PARK;
        end else if (s_mode == MODE_HIZ) begin
            c_d.drv = DRV_HIZ;
        end else begin
            c_d.drv = DRV_ON;
        end

        unique case (s_mult)
            2'b00:   begin c_d.fb = 4'd4; c_d.pre = 2'd1; end
            2'b10:   begin c_d.fb = 4'd6; c_d.pre = 2'd1; end
            2'b11:   begin c_d.fb = 4'd8; c_d.pre = 2'd1; end
            default: begin c_d.fb = 4'd8; c_d.pre = 2'd3; end
        endcase

        if ((s_mode == MODE_REF) && (c_q.prev_mode == MODE_REF)
            && (s_mult != c_q.prev_mult))
            c_d.e_mult = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.src <= SRC_NONE;
            c_q.drv <= DRV_GND;
            c_q.fb  <= 4'd4;
            c_q.pre <= 2'd1;
        end else begin
            c_q <= c_d;
        end
    end

    clkgen_stop_guard #(
        .MIN_ON_CYC   (MIN_ON_CYC),
        .MAX_STOP_CYC (MAX_STOP_CYC)
    ) u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_on       (s_pwr),
        .stop_n       (s_stop_n),
        .err_min_on   (err_min_on),
        .err_max_stop (err_max_stop)
    );

    clkgen_settle_track #(.SETTLE_EDGES(SETTLE_EDGES)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_pwr & s_stop_n),
        .mon_clk (s_mon),
        .settled (settled)
    );

    assign src_sel       = c_q.src;
    assign drv_state     = c_q.drv;
    assign fb_div        = c_q.fb;
    assign pre_div       = c_q.pre;
    assign err_mult_test = c_q.e_mult;
endmodule

// File: rtl/clkgen_mode_ctrl_chk.sv
module clkgen_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_dn_n,
    input logic       clk_stop_n,
    input logic [1:0] mode_sel,
    input logic [1:0] mult_sel,
    input logic       out_clk_mon,
    input logic [1:0] src_sel,
    input logic [1:0] drv_state,
    input logic [3:0] fb_div,
    input logic [1:0] pre_div,
    input logic       settled,
    input logic       err_min_on,
    input logic       err_max_stop,
    input logic       err_mult_test
);
    logic [1:0] arm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             arm_q <= 2'd0;
        else if (arm_q != 2'd3) arm_q <= arm_q + 2'd1;
    end

    assert_pwrdn_ground_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q == 2'd3 && $past(pwr_dn_n, 3) == 1'b0) |-> (drv_state == 2'd2 && src_sel == 2'd0));

    assert_stop_parks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q == 2'd3 && $past(pwr_dn_n, 3) && !$past(clk_stop_n, 3)) |-> (drv_state == 2'd1));

    assert_hiz_no_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_q == 2'd3 && $past(pwr_dn_n, 3) && $past(clk_stop_n, 3) && $past(mode_sel, 3) == 2'b10)
        |-> (drv_state == 2'd3 && src_sel == 2'd0));

    assert_div_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_div == 2'd3) |-> (fb_div == 4'd8));

    assert_min_on_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_min_on |=> err_min_on);

    assert_max_stop_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_max_stop |=> err_max_stop);

    assert_mult_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_mult_test |=> err_mult_test);

    assert_no_settle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_state == 2'd1 || drv_state == 2'd2) |-> !settled);
endmodule

bind clkgen_mode_ctrl clkgen_mode_ctrl_chk u_chk (.*);

// File: tb/tb_clkgen_mode_ctrl.sv
module tb_clkgen_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_dn_n = 1'b1;
    logic       clk_stop_n = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic [1:0] mult_sel = 2'b00;
    logic       out_clk_mon = 1'b0;
    logic       mon_en = 1'b0;
    logic [1:0] src_sel, drv_state, pre_div;
    logic [3:0] fb_div;
    logic       settled, err_min_on, err_max_stop, err_mult_test;

    int n_chk = 0;
    int n_bad = 0;

    localparam int CPU = 40;   // min-on 4 cycles, max-stop 4000 cycles

    clkgen_mode_ctrl #(.CYC_PER_US(CPU)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .clk_stop_n(clk_stop_n),
        .mode_sel(mode_sel), .mult_sel(mult_sel), .out_clk_mon(out_clk_mon),
        .src_sel(src_sel), .drv_state(drv_state), .fb_div(fb_div), .pre_div(pre_div),
        .settled(settled), .err_min_on(err_min_on), .err_max_stop(err_max_stop),
        .err_mult_test(err_mult_test)
    );

    always #4 clk = ~clk;

    always begin
        repeat (4) @(negedge clk);
        if (mon_en) out_clk_mon = ~out_clk_mon;
    end

    function automatic int exp_src(logic pd_n, logic [1:0] m);
        if (!pd_n) return 0;
        case (m)
            2'b00: return 1;
            2'b01: return 2;
            2'b11: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_drv(logic pd_n, logic st_n, logic [1:0] m);
        if (!pd_n) return 2;
        if (!st_n) return 1;
        if (m == 2'b10) return 3;
        return 0;
    endfunction

    function automatic int exp_fb(logic [1:0] u);
        case (u)
            2'b00: return 4;
            2'b10: return 6;
            default: return 8;
        endcase
    endfunction

    function automatic int exp_pre(logic [1:0] u);
        return (u == 2'b01) ? 3 : 1;
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(5);
    endtask

    task automatic check_decode(string tag);
        check({tag, " src"}, int'(src_sel), exp_src(pwr_dn_n, mode_sel));
        check({tag, " drv"}, int'(drv_state), exp_drv(pwr_dn_n, clk_stop_n, mode_sel));
        check({tag, " fb"},  int'(fb_div), exp_fb(mult_sel));
        check({tag, " pre"}, int'(pre_div), exp_pre(mult_sel));
    endtask

    initial begin
        #1600000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R11: reset state
        step(2);
        check("R11 drv", int'(drv_state), 2);
        check("R11 src", int'(src_sel), 0);
        check("R11 settled", int'(settled), 0);
        check("R11 errs", int'({err_min_on, err_max_stop, err_mult_test}), 0);
        rst_n = 1'b1;
        step(1);
        check("R11 drv after release", int'(drv_state), 2);

        // R4 directed: every multiplier code in normal mode
        step(5);
        for (int k = 0; k < 4; k++) begin
            mult_sel = 2'(k);
            step(4);
            check_decode("R4");
        end
        // R3 directed: every mode
        for (int k = 0; k < 4; k++) begin
            mode_sel = 2'(k);
            step(4);
            check_decode("R3");
        end
        // R2 directed
        clk_stop_n = 1'b0; mode_sel = 2'b01;
        step(4);
        check_decode("R2");
        // R1 directed
        pwr_dn_n = 1'b0; clk_stop_n = 1'b1; mode_sel = 2'b11;
        step(4);
        check_decode("R1");

        // R5: latency of exactly three edges
        pwr_dn_n = 1'b1; mode_sel = 2'b00;
        step(6);
        mode_sel = 2'b01;
        step(2);
        check("R5 two edges", int'(src_sel), 1);
        step(1);
        check("R5 three edges", int'(src_sel), 2);

        // R1/R2/R3/R4 random mix
        for (int k = 0; k < 150; k++) begin
            pwr_dn_n   = ($urandom % 4) != 0;
            clk_stop_n = ($urandom % 3) != 0;
            mode_sel   = 2'($urandom);
            mult_sel   = 2'($urandom);
            step(4);
            check_decode("R1/R2/R3/R4 random");
        end

        // R6: minimum on-time
        pwr_dn_n = 1'b1; clk_stop_n = 1'b1; mode_sel = 2'b00; mult_sel = 2'b00;
        do_reset();
        clk_stop_n = 1'b0; step(10);
        check("R6 first stop no err", int'(err_min_on), 0);
        clk_stop_n = 1'b1; step(20);
        clk_stop_n = 1'b0; step(10);
        check("R6 long on no err", int'(err_min_on), 0);
        clk_stop_n = 1'b1; step(1);
        clk_stop_n = 1'b0; step(6);
        check("R6 short on err", int'(err_min_on), 1);
        clk_stop_n = 1'b1; step(30);
        check("R8 min-on sticky", int'(err_min_on), 1);

        // R7: maximum stop time
        do_reset();
        clk_stop_n = 1'b0; step(2000);
        clk_stop_n = 1'b1; step(10);
        check("R7 short stop no err", int'(err_max_stop), 0);
        clk_stop_n = 1'b0; step(8200);
        check("R7 long stop err", int'(err_max_stop), 1);
        clk_stop_n = 1'b1; step(50);
        check("R8 max-stop sticky", int'(err_max_stop), 1);

        // R9: settle counting
        do_reset();
        mon_en = 1'b1;
        clk_stop_n = 1'b0; step(20);
        check("R9 stopped", int'(settled), 0);
        clk_stop_n = 1'b1; step(80);
        check("R9 10 edges", int'(settled), 0);
        step(320);
        check("R9 30+ edges", int'(settled), 1);
        clk_stop_n = 1'b0; step(4);
        check("R9 cleared on stop", int'(settled), 0);
        clk_stop_n = 1'b1; mon_en = 1'b0;

        // R10: multiplier stability in reference mode
        do_reset();
        mode_sel = 2'b00; step(6);
        mult_sel = 2'b11; step(6);
        check("R10 change outside ref", int'(err_mult_test), 0);
        mode_sel = 2'b11; step(6);
        check("R10 enter ref", int'(err_mult_test), 0);
        mult_sel = 2'b10; step(5);
        check("R10 change in ref", int'(err_mult_test), 1);
        mode_sel = 2'b00; step(10);
        check("R8 mult sticky", int'(err_mult_test), 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule